// File: doc/BRIEF.md
# Multi-function pad control bank

This block holds a set of pad control cells, one for each external pad. Software programs each cell through a 32-bit configuration word written over a simple register bus. The configuration word chooses which of eight on-chip peripherals drives the pad, and where the pull resistor settings come from. It also sets the drive/slew code that is handed to the pad, and sets what the pad does while the chip is in low-power mode.

Each cell samples its pad input through a two-stage synchroniser and watches it for rising and falling edges. An enabled edge sets a sticky status bit. Software clears that bit by writing a 1 to it. While the low-power input is high, any set status bit raises a shared wake output.

The register space has two words for each pad. Address bit 0 selects the configuration word (0) or the status word (1). The upper address bits give the pad index. Reads are combinational from the address. Writes take effect on the clock edge when the write enable is high.

Top module: `padmux_bank`

## Requirements
- R1: After reset every configuration word reads 0x0000_0840. In that value the function is 0, the drive code is 2, bit 6 (detection off) is 1, and bit 15 is 0, so the peripheral controls the pulls. Every status word reads 0.
- R2: Bits 31:16 and bit 3 of a configuration word always read 0. Writes to those bits are ignored, so writing 0xFFFF_FFFF reads back as 0x0000_FFF7.
- R3: Outside low-power override, pad output and pad output enable come from the peripheral whose index is in configuration bits 2:0.
- R4: When low-power is high and configuration bit 9 is 1, the pad output enable equals the inverse of bit 7 and the pad output equals bit 8. When bit 9 is 0, or low-power is low, R3 applies.
- R5: When configuration bit 15 is 1, the pad pull-up follows bit 14 and the pad pull-down follows bit 13. When bit 15 is 0, both follow the pull requests of the selected peripheral.
- R6: The pad drive code output equals configuration bits 12:10, unchanged.
- R7: With bit 4 set and bit 6 clear, a synchronised rising edge on the pad input sets the pad's status bit 0. With only bit 4 set, a falling edge does not set it.
- R8: With bit 5 set and bit 6 clear, a synchronised falling edge sets status bit 0. With only bit 5 set, a rising edge does not set it.
- R9: With bit 6 set, no edge sets the status bit, whatever bits 4 and 5 hold.
- R10: A set status bit stays set until a write with data bit 0 = 1 to that pad's status word clears it. A write with data bit 0 = 0 leaves it set.
- R11: The wake output is high exactly when low-power is high and at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | ADDR_W | {pad index, word select}; word select 0 = config, 1 = status |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| periphOut | input | NUM_PADS*8 | Per-pad, per-function output data |
| periphOe | input | NUM_PADS*8 | Per-pad, per-function output enable |
| periphPullUp | input | NUM_PADS*8 | Per-pad, per-function pull-up request |
| periphPullDn | input | NUM_PADS*8 | Per-pad, per-function pull-down request |
| padIn | input | NUM_PADS | Asynchronous pad input levels |
| lowPower | input | 1 | Low-power mode indication |
| padOut | output | NUM_PADS | Pad output data |
| padOe | output | NUM_PADS | Pad output enable |
| padPullUp | output | NUM_PADS | Pad pull-up enable |
| padPullDn | output | NUM_PADS | Pad pull-down enable |
| padDrive | output | NUM_PADS*3 | Pad drive/slew code |
| wake | output | 1 | Wake request |

## Verification
The output mux is exercised by stepping the function select through all eight values against two complementary data patterns and a separate enable pattern. A stuck or swapped select bit therefore shows up as a wrong bit on at least one step.

Edge detection is tried with a rising-only setting, a falling-only setting and a both-plus-disable setting. Each setting sees both pad transitions, so swapped enables, a missing disable and a missing synchroniser all give distinct failures.

Low-power override and pull-source selection are each driven with the peripheral's request opposite to the register's value. The observed pad level then shows which source was used.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int CFG_W      = 32;
  localparam int FUNC_W     = 3;
  localparam int NUM_FUNCS  = 1 << FUNC_W;
  localparam int DRV_W      = 3;
  localparam int DRV_LSB    = 10;
  localparam int BIT_RISE   = 4;
  localparam int BIT_FALL   = 5;
  localparam int BIT_EDGOFF = 6;
  localparam int BIT_LPOEN  = 7;
  localparam int BIT_LPDAT  = 8;
  localparam int BIT_LPSEL  = 9;
  localparam int BIT_PD     = 13;
  localparam int BIT_PU     = 14;
  localparam int BIT_PSRC   = 15;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0840;
  localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_FFF7;

  typedef struct packed {
    logic cfgWe;
    logic stsClr;
  } padStrobe_t;
endpackage

// File: rtl/padmux_cell.sv
module padmux_cell
  import padmux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  padStrobe_t           strobe,
  input  logic [CFG_W-1:0]     wrData,
  input  logic [NUM_FUNCS-1:0] fnOut,
  input  logic [NUM_FUNCS-1:0] fnOe,
  input  logic [NUM_FUNCS-1:0] fnPullUp,
  input  logic [NUM_FUNCS-1:0] fnPullDn,
  input  logic                 padIn,
  input  logic                 lowPower,
  output logic [CFG_W-1:0]     cfg,
  output logic                 edgeSts,
  output logic                 padOut,
  output logic                 padOe,
  output logic                 padPullUp,
  output logic                 padPullDn,
  output logic [DRV_W-1:0]     padDrive
);
  logic [CFG_W-1:0]  cfgQ;
  logic [FUNC_W-1:0] fnSel;
  logic syncA, syncB, syncPrev;
  logic riseHit, fallHit, edgeHit, lpActive, stsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= CFG_RESET;
    else if (strobe.cfgWe) cfgQ <= wrData & CFG_WMASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign riseHit = syncB & ~syncPrev & cfgQ[BIT_RISE];
  assign fallHit = ~syncB & syncPrev & cfgQ[BIT_FALL];
  assign edgeHit = (riseHit | fallHit) & ~cfgQ[BIT_EDGOFF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stsQ <= 1'b0;
    else if (edgeHit)       stsQ <= 1'b1;
    else if (strobe.stsClr) stsQ <= 1'b0;
  end

  assign fnSel    = cfgQ[FUNC_W-1:0];
  assign lpActive = lowPower & cfgQ[BIT_LPSEL];

  always_comb begin
    padOut    = lpActive ? cfgQ[BIT_LPDAT] : fnOut[fnSel];
    padOe     = lpActive ? ~cfgQ[BIT_LPOEN] : fnOe[fnSel];
    padPullUp = cfgQ[BIT_PSRC] ? cfgQ[BIT_PU] : fnPullUp[fnSel];
    padPullDn = cfgQ[BIT_PSRC] ? cfgQ[BIT_PD] : fnPullDn[fnSel];
  end

  assign padDrive = cfgQ[DRV_LSB +: DRV_W];
  assign cfg      = cfgQ;
  assign edgeSts  = stsQ;
endmodule

// File: rtl/padmux_datapath.sv
module padmux_datapath
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  padStrobe_t [NUM_PADS-1:0]     strobe,
  input  logic [CFG_W-1:0]              wrData,
  input  logic [NUM_PADS*NUM_FUNCS-1:0] periphOut,
  input  logic [NUM_PADS*NUM_FUNCS-1:0] periphOe,
  input  logic [NUM_PADS*NUM_FUNCS-1:0] periphPullUp,
  input  logic [NUM_PADS*NUM_FUNCS-1:0] periphPullDn,
  input  logic [NUM_PADS-1:0]           padIn,
  input  logic                          lowPower,
  output logic [NUM_PADS*CFG_W-1:0]     cfgAll,
  output logic [NUM_PADS-1:0]           stsAll,
  output logic [NUM_PADS-1:0]           padOut,
  output logic [NUM_PADS-1:0]           padOe,
  output logic [NUM_PADS-1:0]           padPullUp,
  output logic [NUM_PADS-1:0]           padPullDn,
  output logic [NUM_PADS*DRV_W-1:0]     padDrive,
  output logic                          wake
);
  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    padmux_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe[i]),
      .wrData   (wrData),
      .fnOut    (periphOut[i*NUM_FUNCS +: NUM_FUNCS]),
      .fnOe     (periphOe[i*NUM_FUNCS +: NUM_FUNCS]),
      .fnPullUp (periphPullUp[i*NUM_FUNCS +: NUM_FUNCS]),
      .fnPullDn (periphPullDn[i*NUM_FUNCS +: NUM_FUNCS]),
      .padIn    (padIn[i]),
      .lowPower (lowPower),
      .cfg      (cfgAll[i*CFG_W +: CFG_W]),
      .edgeSts  (stsAll[i]),
      .padOut   (padOut[i]),
      .padOe    (padOe[i]),
      .padPullUp(padPullUp[i]),
      .padPullDn(padPullDn[i]),
      .padDrive (padDrive[i*DRV_W +: DRV_W])
    );
  end

  assign wake = lowPower & (|stsAll);
endmodule

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = 3
) (
  input  logic                      regWe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      wrBit0,
  input  logic [NUM_PADS*CFG_W-1:0] cfgAll,
  input  logic [NUM_PADS-1:0]       stsAll,
  output padStrobe_t [NUM_PADS-1:0] strobe,
  output logic [CFG_W-1:0]          regRdata
);
  logic [IDX_W-1:0] padIdx;
  logic             stsSel;

  assign padIdx = regAddr[ADDR_W-1:1];
  assign stsSel = regAddr[0];

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_dec
    logic hit;
    assign hit              = regWe && (padIdx == IDX_W'(i));
    assign strobe[i].cfgWe  = hit && !stsSel;
    assign strobe[i].stsClr = hit && stsSel && wrBit0;
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_PADS; i++) begin
      if (padIdx == IDX_W'(i))
        regRdata = stsSel ? {{(CFG_W-1){1'b0}}, stsAll[i]} : cfgAll[i*CFG_W +: CFG_W];
    end
  end
endmodule

// File: rtl/padmux_bank.sv
module padmux_bank
  import padmux_pkg::*;
#(
  parameter int NUM_PADS = 4,
  localparam int IDX_W   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1,
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [31:0]                   regWdata,
  output logic [31:0]                   regRdata,
  input  logic [NUM_PADS*8-1:0]         periphOut,
  input  logic [NUM_PADS*8-1:0]         periphOe,
  input  logic [NUM_PADS*8-1:0]         periphPullUp,
  input  logic [NUM_PADS*8-1:0]         periphPullDn,
  input  logic [NUM_PADS-1:0]           padIn,
  input  logic                          lowPower,
  output logic [NUM_PADS-1:0]           padOut,
  output logic [NUM_PADS-1:0]           padOe,
  output logic [NUM_PADS-1:0]           padPullUp,
  output logic [NUM_PADS-1:0]           padPullDn,
  output logic [NUM_PADS*3-1:0]         padDrive,
  output logic                          wake
);
  padStrobe_t [NUM_PADS-1:0]   strobe;
  logic [NUM_PADS*CFG_W-1:0]   cfgAll;
  logic [NUM_PADS-1:0]         stsAll;
  logic [NUM_PADS-1:0]         clrStb;

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_clr
    assign clrStb[i] = strobe[i].stsClr;
  end

  padmux_ctrl #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .wrBit0  (regWdata[0]),
    .cfgAll  (cfgAll),
    .stsAll  (stsAll),
    .strobe  (strobe),
    .regRdata(regRdata)
  );

  padmux_datapath #(.NUM_PADS(NUM_PADS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (regWdata),
    .periphOut   (periphOut),
    .periphOe    (periphOe),
    .periphPullUp(periphPullUp),
    .periphPullDn(periphPullDn),
    .padIn       (padIn),
    .lowPower    (lowPower),
    .cfgAll      (cfgAll),
    .stsAll      (stsAll),
    .padOut      (padOut),
    .padOe       (padOe),
    .padPullUp   (padPullUp),
    .padPullDn   (padPullDn),
    .padDrive    (padDrive),
    .wake        (wake)
  );
endmodule

// File: rtl/padmux_bank_checker.sv
module padmux_bank_checker #(
  parameter int NUM_PADS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [31:0]            regRdata,
  input logic                   wake,
  input logic                   lowPower,
  input logic [NUM_PADS-1:0]    stsAll,
  input logic [NUM_PADS-1:0]    clrStb,
  input logic [NUM_PADS*32-1:0] cfgAll
);
  // R2: reserved bits never appear on the read bus
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[31:16] == 16'd0) && !regRdata[3]);

  // R11: wake only in low-power mode
  p_wake_gated_r11: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> lowPower);

  // R11: wake needs some pending status
  p_wake_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stsAll == '0) |-> !wake);

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    // R10: a set status bit survives every cycle without a clear strobe
    p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      (stsAll[i] && !clrStb[i]) |=> stsAll[i]);

    // R9: detection off keeps a clear status bit clear
    p_edge_off_r9: assert property (@(posedge clk) disable iff (!rstN)
      (cfgAll[i*32 + 6] && !stsAll[i]) |=> !stsAll[i]);
  end
endmodule

bind padmux_bank padmux_bank_checker #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regRdata(regRdata),
  .wake    (wake),
  .lowPower(lowPower),
  .stsAll  (stsAll),
  .clrStb  (clrStb),
  .cfgAll  (cfgAll)
);

// File: tb/padmux_bank_bench.sv
module padmux_bank_bench;
  localparam int NP    = 4;
  localparam int IDXW  = 2;
  localparam int AW    = IDXW + 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWe = 1'b0;
  logic [AW-1:0]   regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NP*8-1:0] periphOut = '0, periphOe = '0, periphPullUp = '0, periphPullDn = '0;
  logic [NP-1:0]   padIn = '0;
  logic            lowPower = 1'b0;
  logic [NP-1:0]   padOut, padOe, padPullUp, padPullDn;
  logic [NP*3-1:0] padDrive;
  logic            wake;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  padmux_bank #(.NUM_PADS(NP)) u_padmux_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .periphOut(periphOut), .periphOe(periphOe),
    .periphPullUp(periphPullUp), .periphPullDn(periphPullDn), .padIn(padIn),
    .lowPower(lowPower), .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .padPullDn(padPullDn), .padDrive(padDrive), .wake(wake));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int pad, input bit sts, input logic [31:0] data);
    @(negedge clk);
    regAddr = {IDXW'(pad), sts};
    regWdata = data;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    #1;
  endtask

  task automatic rdReg(input int pad, input bit sts, output logic [31:0] data);
    @(negedge clk);
    regAddr = {IDXW'(pad), sts};
    #1;
    data = regRdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      rdReg(p, 0, d); check("R1 config reset", d, 32'h0000_0840);
      rdReg(p, 1, d); check("R1 status reset", d, 32'h0);
    end
    check("R6 drive reset", {29'd0, padDrive[2:0]}, 32'd2);
    check("R11 wake reset", {31'd0, wake}, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wrReg(1, 0, 32'hFFFF_FFFF);
    rdReg(1, 0, d); check("R2 reserved masked", d, 32'h0000_FFF7);
    check("R6 drive all ones", {29'd0, padDrive[5:3]}, 32'd7);
    wrReg(1, 0, 32'h0000_1400);
    check("R6 drive code 5", {29'd0, padDrive[5:3]}, 32'd5);
  endtask

  task automatic t_mux();
    for (int k = 0; k < 8; k++) begin
      wrReg(0, 0, 32'h40 | k);
      periphOut[7:0] = 8'hA5; periphOe[7:0] = 8'h3C; #1;
      check($sformatf("R3 out fn%0d", k), {31'd0, padOut[0]}, {31'd0, 8'hA5 >> k & 1'b1});
      check($sformatf("R3 oe fn%0d", k), {31'd0, padOe[0]}, {31'd0, 8'h3C >> k & 1'b1});
      periphOut[7:0] = 8'h5A; #1;
      check($sformatf("R3 out inv fn%0d", k), {31'd0, padOut[0]}, {31'd0, 8'h5A >> k & 1'b1});
    end
  endtask

  task automatic t_lowpower();
    // pad 2: function 1 drives 0 with oe 0
    periphOut[23:16] = 8'h00; periphOe[23:16] = 8'h00;
    wrReg(2, 0, 32'h0000_0341);          // sel=1, lpData=1, lpOeN=0, fn 1
    lowPower = 1'b1; #1;
    check("R4 lp oe on", {31'd0, padOe[2]}, 32'd1);
    check("R4 lp data", {31'd0, padOut[2]}, 32'd1);
    wrReg(2, 0, 32'h0000_03C1);          // lpOeN=1
    check("R4 lp oe off", {31'd0, padOe[2]}, 32'd0);
    wrReg(2, 0, 32'h0000_0141);          // lpSel=0 -> peripheral
    periphOut[17] = 1'b1; periphOe[17] = 1'b1; #1;
    check("R4 lpsel0 data", {31'd0, padOut[2]}, 32'd1);
    wrReg(2, 0, 32'h0000_0241);          // lpSel=1, lpData=0
    lowPower = 1'b0; #1;
    check("R4 run mode data", {31'd0, padOut[2]}, 32'd1);
    check("R4 run mode oe", {31'd0, padOe[2]}, 32'd1);
  endtask

  task automatic t_pull();
    periphPullUp[15:8] = 8'h00; periphPullDn[15:8] = 8'hFF;
    wrReg(1, 0, 32'h0000_C042);          // src=reg, pu=1, pd=0, fn 2
    check("R5 reg pu", {31'd0, padPullUp[1]}, 32'd1);
    check("R5 reg pd", {31'd0, padPullDn[1]}, 32'd0);
    wrReg(1, 0, 32'h0000_4042);          // src=periph
    check("R5 periph pu", {31'd0, padPullUp[1]}, 32'd0);
    check("R5 periph pd", {31'd0, padPullDn[1]}, 32'd1);
    periphPullUp[10] = 1'b1; periphPullDn[10] = 1'b0; #1;
    check("R5 periph fn2 pu", {31'd0, padPullUp[1]}, 32'd1);
    check("R5 periph fn2 pd", {31'd0, padPullDn[1]}, 32'd0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wrReg(3, 0, 32'h0000_0810);          // rise only
    settle(); rdReg(3, 1, d); check("R7 no spurious", d, 32'd0);
    padIn[3] = 1'b1; settle();
    rdReg(3, 1, d); check("R7 rise sets", d, 32'd1);
    wrReg(3, 1, 32'h0);
    rdReg(3, 1, d); check("R10 write0 keeps", d, 32'd1);
    lowPower = 1'b0; #1;
    check("R11 no wake outside lp", {31'd0, wake}, 32'd0);
    lowPower = 1'b1; #1;
    check("R11 wake in lp", {31'd0, wake}, 32'd1);
    wrReg(3, 1, 32'h1);
    rdReg(3, 1, d); check("R10 write1 clears", d, 32'd0);
    check("R11 wake drops", {31'd0, wake}, 32'd0);
    lowPower = 1'b0;
    padIn[3] = 1'b0; settle();
    rdReg(3, 1, d); check("R7 fall ignored", d, 32'd0);
    wrReg(3, 0, 32'h0000_0820);          // fall only
    padIn[3] = 1'b1; settle();
    rdReg(3, 1, d); check("R8 rise ignored", d, 32'd0);
    padIn[3] = 1'b0; settle();
    rdReg(3, 1, d); check("R8 fall sets", d, 32'd1);
    wrReg(3, 1, 32'h1);
    wrReg(3, 0, 32'h0000_0870);          // both + disable
    padIn[3] = 1'b1; settle();
    padIn[3] = 1'b0; settle();
    rdReg(3, 1, d); check("R9 disabled", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_reserved();
    t_mux();
    t_lowpower();
    t_pull();
    t_edges();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule